// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switcher

This block drives one output clock from either of two reference clocks, `clk0` or `clk1`, and changes between them without ever producing a shortened high pulse. A plain request pin, `switch_req`, is synchronised into a free-running check clock. Each qualified low-to-high edge of the request flips the selection. Holding the request high, or letting it fall, does nothing. To switch again, the request must first go low.

A switch happens in two halves. First, the enable of the clock now in use is withdrawn, and that clock's own domain applies the change on its falling edge. Only after that withdrawal has been acknowledged back in the check domain does the block enable the incoming clock, again on that clock's falling edge. Each source clock has an activity monitor that raises a per-clock bad flag when the clock stops toggling. The controller will not enable a source that is flagged bad; it waits until the source recovers. The `active_sel` output names the source that is actually feeding the output.

Top module: `clk_switchover`

## Requirements
- R1: While `rst_n` is low and right after it rises, `active_sel` is 0, both bad flags are 0, and `clk_out` follows `clk0`.
- R2: A request is accepted only after `switch_req`, as seen through a two-flop synchroniser in the `chk_clk` domain, has been high for 3 consecutive `chk_clk` cycles following a low level. A one-cycle pulse causes no switch.
- R3: The outgoing source is gated off on its own falling edge. Every high pulse on `clk_out` is a full high phase of the source that produced it: 5 ns for `clk0` or 7 ns for `clk1` in the bench.
- R4: The incoming source is enabled on its falling edge, and only after the outgoing source's disable has been acknowledged. The two sources are never enabled together, and once the switch completes, `clk_out` follows the new source.
- R5: `active_sel` reads 0 for `clk0` and 1 for `clk1`. It changes only when the new source is already enabled and feeding `clk_out`.
- R6: Each accepted request causes exactly one switch. Keeping `switch_req` high afterwards, or dropping it, causes no further switch.
- R7: After `switch_req` has returned low, a new qualified rising edge toggles the selection again, so the block can switch back.
- R8: If the target source is flagged bad, the switch waits with `clk_out` held low and `active_sel` unchanged. It completes on its own once the source toggles again.
- R9: While both sources run, both bad flags stay 0 throughout manual switches.
- R10: A source's bad flag rises when no edge of that source is seen within `ACT_WINDOW` `chk_clk` cycles, and it falls once edges return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Reference source 0, selected after reset |
| clk1 | input | 1 | Reference source 1 |
| chk_clk | input | 1 | Free-running clock for control, qualification and activity checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| switch_req | input | 1 | Asynchronous manual switch request, acted on at qualified rising edges |
| clk_out | output | 1 | Glitch-free selected clock |
| active_sel | output | 1 | Source feeding clk_out (0 = clk0, 1 = clk1) |
| bad0 | output | 1 | clk0 showed no edges within the activity window |
| bad1 | output | 1 | clk1 showed no edges within the activity window |

## Verification
A corrupted enable register shows up at once on `clk_out`. Either a high pulse of the wrong width appears within one source half-period, or the output stops following its source within one period. A wrong controller state or selection bit shows on `active_sel` at the next `chk_clk` comparison, because the bench model knows which source must be active outside switch windows. A broken qualifier or activity counter shows as a switch that is missing or extra, or as a bad flag that is wrong, within a few tens of `chk_clk` cycles of the stimulus.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    SW_IDLE,
    SW_DROP,
    SW_WAIT,
    SW_RAISE
  } sw_state_e;
endpackage

// File: rtl/clksw_req_qual.sv
module clksw_req_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic fire
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;
  logic                   armed;
  logic                   req_s;

  assign req_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      fire  <= 1'b0;
    end else if (!req_s) begin
      cnt   <= '0;
      armed <= 1'b1;
      fire  <= 1'b0;
    end else if (armed) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        armed <= 1'b0;
        fire  <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        fire <= 1'b0;
      end
    end else begin
      fire <= 1'b0;
    end
  end
endmodule

// File: rtl/clksw_gate.sv
module clksw_gate #(
  parameter int SYNC_STAGES = 2,
  parameter bit RST_EN      = 1'b0
) (
  input  logic clk_in,
  input  logic chk_clk,
  input  logic rst_n,
  input  logic en_req,
  output logic clk_gated,
  output logic en_ack
);
  logic [SYNC_STAGES-1:0] in_sync;
  logic [SYNC_STAGES-1:0] ack_sync;
  logic                   en_q;

  // request crosses into the source domain
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) in_sync <= {SYNC_STAGES{RST_EN}};
    else        in_sync <= {in_sync[SYNC_STAGES-2:0], en_req};
  end

  // enable only moves while the source is low
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_q <= RST_EN;
    else        en_q <= in_sync[SYNC_STAGES-1];
  end

  assign clk_gated = clk_in & en_q;

  // applied enable returns to the check domain
  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) ack_sync <= {SYNC_STAGES{RST_EN}};
    else        ack_sync <= {ack_sync[SYNC_STAGES-2:0], en_q};
  end

  assign en_ack = ack_sync[SYNC_STAGES-1];
endmodule

// File: rtl/clksw_activity.sv
module clksw_activity #(
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW      = 16
) (
  input  logic clk_in,
  input  logic chk_clk,
  input  logic rst_n,
  output logic dead
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIM = CW'(WINDOW);

  logic                 tog;
  logic [SYNC_STAGES:0] s_q;
  logic [CW-1:0]        cnt;
  logic                 edge_seen;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= {s_q[SYNC_STAGES-1:0], tog};
  end

  assign edge_seen = s_q[SYNC_STAGES] ^ s_q[SYNC_STAGES-1];

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dead <= 1'b0;
    end else if (edge_seen) begin
      cnt  <= '0;
      dead <= 1'b0;
    end else if (cnt == LIM) begin
      dead <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_switchover.sv
module clk_switchover #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 3,
  parameter int ACT_WINDOW  = 16
) (
  input  logic clk0,
  input  logic clk1,
  input  logic chk_clk,
  input  logic rst_n,
  input  logic switch_req,
  output logic clk_out,
  output logic active_sel,
  output logic bad0,
  output logic bad1
);
  import clksw_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0] src;
  logic [NSRC-1:0] gated;
  logic [NSRC-1:0] en_req;
  logic [NSRC-1:0] ack;
  logic [NSRC-1:0] bad;
  logic            fire;
  logic            sel;
  sw_state_e       state;

  assign src = {clk1, clk0};

  clksw_req_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_CYC   (QUAL_CYC)
  ) u_qual (
    .clk      (chk_clk),
    .rst_n    (rst_n),
    .req_async(switch_req),
    .fire     (fire)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    clksw_gate #(
      .SYNC_STAGES(SYNC_STAGES),
      .RST_EN     (i == 0)
    ) u_gate (
      .clk_in   (src[i]),
      .chk_clk  (chk_clk),
      .rst_n    (rst_n),
      .en_req   (en_req[i]),
      .clk_gated(gated[i]),
      .en_ack   (ack[i])
    );

    clksw_activity #(
      .SYNC_STAGES(SYNC_STAGES),
      .WINDOW     (ACT_WINDOW)
    ) u_act (
      .clk_in (src[i]),
      .chk_clk(chk_clk),
      .rst_n  (rst_n),
      .dead   (bad[i])
    );
  end

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SW_IDLE;
      sel    <= 1'b0;
      en_req <= 2'b01;
    end else begin
      case (state)
        SW_IDLE: if (fire) begin
          en_req[sel] <= 1'b0;
          state       <= SW_DROP;
        end
        SW_DROP: if (!ack[sel]) state <= SW_WAIT;
        SW_WAIT: if (!bad[~sel]) begin
          en_req[~sel] <= 1'b1;
          state        <= SW_RAISE;
        end
        SW_RAISE: if (ack[~sel]) begin
          sel   <= ~sel;
          state <= SW_IDLE;
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  assign clk_out    = |gated;
  assign active_sel = sel;
  assign bad0       = bad[0];
  assign bad1       = bad[1];
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker (
  input logic                 chk_clk,
  input logic                 rst_n,
  input logic                 fire,
  input clksw_pkg::sw_state_e state,
  input logic [1:0]           ack,
  input logic [1:0]           bad,
  input logic                 sel
);
  import clksw_pkg::*;

  p_one_source_r4: assert property (@(posedge chk_clk) disable iff (!rst_n)
    !(ack[0] && ack[1]));

  p_idle_hold_r2: assert property (@(posedge chk_clk) disable iff (!rst_n)
    (state == SW_IDLE && !fire) |=> (state == SW_IDLE && $stable(sel)));

  p_single_fire_r6: assert property (@(posedge chk_clk) disable iff (!rst_n)
    fire |=> !fire);

  p_wait_dead_r8: assert property (@(posedge chk_clk) disable iff (!rst_n)
    (state == SW_WAIT && bad[~sel]) |=> (state == SW_WAIT));

  p_sel_feeds_r5: assert property (@(posedge chk_clk) disable iff (!rst_n)
    ($rose(sel) || $fell(sel)) |-> ack[sel]);
endmodule

bind clk_switchover clksw_checker u_chk (
  .chk_clk(chk_clk),
  .rst_n  (rst_n),
  .fire   (fire),
  .state  (state),
  .ack    (ack),
  .bad    (bad),
  .sel    (sel)
);

// File: tb/clk_switchover_bench.sv
`timescale 1ns/1ps
module clk_switchover_bench;
  logic clk0 = 1'b0, clk1 = 1'b0, chk_clk = 1'b0;
  logic rst_n = 1'b0, switch_req = 1'b0;
  logic run1 = 1'b1;
  logic clk_out, active_sel, bad0, bad1;

  int  tests = 0, fails = 0;
  bit  done = 1'b0;
  // behavioural reference state
  int  exp_sel = 0;
  int  exp_bad1 = 0;
  bit  busy = 1'b0;
  bit  mon_on = 1'b0;
  realtime t_rise = 0.0;

  always #4 chk_clk = ~chk_clk;
  always #5 clk0 = ~clk0;
  always #7 if (run1) clk1 = ~clk1;

  clk_switchover u_clk_switchover (
    .clk0(clk0), .clk1(clk1), .chk_clk(chk_clk), .rst_n(rst_n),
    .switch_req(switch_req), .clk_out(clk_out), .active_sel(active_sel),
    .bad0(bad0), .bad1(bad1)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R5, R9, R10)
  always @(negedge chk_clk) begin
    if (rst_n && !busy && !done) begin
      check(active_sel == exp_sel, "R5 active_sel vs model", active_sel, exp_sel);
      check(bad0 == 1'b0, "R9 bad0 while clk0 runs", bad0, 0);
      if (exp_bad1 >= 0) check(bad1 == exp_bad1[0], "R9 bad1 vs model", bad1, exp_bad1);
    end
  end

  // pulse width monitor (R3)
  always @(posedge clk_out) t_rise = $realtime;
  always @(negedge clk_out) begin
    if (mon_on) begin
      realtime w;
      w = $realtime - t_rise;
      check((w > 4.9 && w < 5.1) || (w > 6.9 && w < 7.1),
            "R3 clk_out high pulse width ps", int'(w * 1000.0), 5000);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge chk_clk);
  endtask

  task automatic follows(input int s, input string tag);
    for (int k = 0; k < 6; k++) begin
      if (s == 0) @(posedge clk0); else @(posedge clk1);
      #2 check(clk_out == 1'b1, tag, clk_out, 1);
      if (s == 0) @(negedge clk0); else @(negedge clk1);
      #2 check(clk_out == 1'b0, tag, clk_out, 0);
    end
  endtask

  task automatic wait_sel(input int v, input string tag);
    int k;
    for (k = 0; k < 300; k++) begin
      @(negedge chk_clk);
      if (active_sel == v[0]) break;
    end
    check(active_sel == v[0], tag, active_sel, v);
  endtask

  task automatic pulse(input int n);
    @(negedge chk_clk) switch_req = 1'b1;
    cycles(n);
    switch_req = 1'b0;
  endtask

  initial begin
    cycles(5);
    check(active_sel == 1'b0, "R1 active_sel in reset", active_sel, 0);
    check(bad0 == 1'b0 && bad1 == 1'b0, "R1 bad flags in reset", {bad1, bad0}, 0);
    @(negedge chk_clk) rst_n = 1'b1;
    check(active_sel == 1'b0, "R1 active_sel after reset", active_sel, 0);
    mon_on = 1'b1;
    follows(0, "R1 clk_out follows clk0 after reset");

    // R2: one-cycle pulse is filtered
    pulse(1);
    cycles(60);
    check(active_sel == 1'b0, "R2 short pulse ignored", active_sel, 0);
    follows(0, "R2 clk_out still clk0");

    // R4 R5: qualified request, held high afterwards
    busy = 1'b1;
    @(negedge chk_clk) switch_req = 1'b1;
    wait_sel(1, "R5 switched to clk1");
    exp_sel = 1; busy = 1'b0;
    follows(1, "R4 clk_out follows clk1");
    cycles(200);
    check(active_sel == 1'b1, "R6 held request no second switch", active_sel, 1);
    switch_req = 1'b0;
    cycles(60);
    check(active_sel == 1'b1, "R6 falling request no switch back", active_sel, 1);

    // R7: new rising edge switches back
    busy = 1'b1;
    pulse(10);
    wait_sel(0, "R7 switched back to clk0");
    exp_sel = 0; busy = 1'b0;
    follows(0, "R7 clk_out follows clk0 again");

    // R10: stop clk1 and see it flagged
    exp_bad1 = -1;
    wait (clk1 == 1'b0);
    run1 = 1'b0;
    cycles(60);
    check(bad1 == 1'b1, "R10 bad1 raised for stopped clk1", bad1, 1);

    // R8: switch to a dead source waits with output low
    busy = 1'b1;
    pulse(10);
    cycles(60);
    check(active_sel == 1'b0, "R8 no switch to dead clk1", active_sel, 0);
    for (int k = 0; k < 10; k++) begin
      #3 check(clk_out == 1'b0, "R8 clk_out held low while waiting", clk_out, 0);
    end
    run1 = 1'b1;
    wait_sel(1, "R8 switch completes after clk1 resumes");
    exp_sel = 1; busy = 1'b0;
    cycles(40);
    check(bad1 == 1'b0, "R10 bad1 clears once clk1 toggles", bad1, 0);
    exp_bad1 = 0;
    follows(1, "R8 clk_out follows revived clk1");

    // R1: asynchronous reset mid-run
    mon_on = 1'b0;
    busy = 1'b1;
    #3 rst_n = 1'b0;
    #1 check(active_sel == 1'b0, "R1 async reset selects clk0", active_sel, 0);
    exp_sel = 0;
    cycles(3);
    @(negedge chk_clk) rst_n = 1'b1;
    busy = 1'b0;
    @(negedge clk0) mon_on = 1'b1;
    follows(0, "R1 clk_out follows clk0 after second reset");
    cycles(10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule